// File: doc/BRIEF.md
# Q1.15 square root by normalised quartic evaluation

The block takes a non-negative Q1.15 sample and returns its square root, also in Q1.15. The input is first normalised by counting its leading zero bits and shifting left, so the mantissa lies in [0.5, 1). That mantissa is mapped onto [-1, 1) and fed to a fourth-order polynomial that approximates the square root. The polynomial is evaluated by Horner's rule with 32-bit fractional coefficients.

If the normalisation shift was odd, the polynomial value is scaled by 1/sqrt(2). The result is then shifted right by half of the shift count, rounded, and truncated to 16 bits.

Each Horner step has its own pipeline stage, so the block accepts one sample on every clock cycle and returns each result a fixed number of cycles later. A valid flag travels with each sample. No handshake is provided.

Top module: `sqrt_q15_poly`

## Requirements
- R1: A sample accepted while `in_vld` is high produces exactly one result with `out_vld` high exactly 7 clock cycles later. `out_vld` stays low in cycles whose matching input cycle had `in_vld` low.
- R2: While `rst_n` is low and on the first cycle after reset, `out_vld` is low.
- R3: For every input x from 0 to 32767 (value x/32768), the result y satisfies |y - 32768*sqrt(x/32768)| < 1.
- R4: An input of 0 gives a result of exactly 0.
- R5: The result never has bit 15 set. The largest input, 0x7FFF, gives 0x7FFF, because rounding saturates instead of wrapping.
- R6: `in_x` is ignored when `in_vld` is low. Cycles with `in_vld` low, even with in_x = 0xFFFF, create no result and do not disturb neighbouring samples.
- R7: Odd normalisation shifts use the 1/sqrt(2) correction. Input 0x2000 (0.25, a shift of 1) gives exactly 0x4000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Input sample valid |
| in_x | input | 16 | Q1.15 input, bit 15 must be 0 |
| out_vld | output | 1 | Result valid |
| out_y | output | 16 | Q1.15 square root |

## Verification
Every result is due exactly 7 rising edges after the edge that captured its input. This delay covers one normalisation stage, four Horner stages, one correction stage and one rounding stage.

The bench drives inputs just after each falling edge and records the cycle in which each sample was sent. It reads the outputs at the next falling edge, where it expects the oldest outstanding sample and checks that its age is exactly 7 cycles.

Idle cycles carrying junk data are inserted into the sweep. Because each result is matched to its own input, a lost, extra or shifted result is caught.

// File: rtl/sqrt_q15_poly.sv
module sqrt_q15_poly (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_vld,
  input  logic [15:0] in_x,
  output logic        out_vld,
  output logic [15:0] out_y
);
  localparam int NSTEP = 4;
  localparam int LAT   = NSTEP + 3;
  localparam logic signed [31:0] COEF [0:NSTEP] = '{
    32'shFFF1203D, 32'sh004581E7, 32'shFE7645AF, 32'sh1278CF97, 32'sh6ED9E687};
  localparam logic signed [31:0] CENTER = 32'sh60000000;
  localparam logic signed [15:0] INV_RT2_HI = 16'sh5A82;

  function automatic logic signed [31:0] mul_hr(input logic signed [31:0] a,
                                                input logic signed [31:0] b);
    logic signed [47:0] p;
    p = $signed(a[31:16]) * b + 48'sd16384;
    return p[46:15];
  endfunction

  function automatic logic signed [31:0] add_sat(input logic signed [31:0] a,
                                                 input logic signed [31:0] b);
    logic signed [32:0] s;
    s = {a[31], a} + {b[31], b};
    if (s[32] != s[31]) return s[32] ? 32'sh80000000 : 32'sh7FFFFFFF;
    return s[31:0];
  endfunction

  function automatic logic [3:0] lead_zeros(input logic [14:0] v);
    logic [3:0] n;
    n = 4'd15;
    for (int i = 0; i < 15; i++) if (v[i]) n = 4'(14 - i);
    return n;
  endfunction

  logic [3:0]         sh_in;
  logic signed [31:0] xn;
  assign sh_in = lead_zeros(in_x[14:0]);
  assign xn    = $signed({in_x, 16'h0000} << sh_in);

  logic               v_p   [0:NSTEP];
  logic signed [31:0] t_p   [0:NSTEP];
  logic signed [31:0] acc_p [0:NSTEP];
  logic               odd_p [0:NSTEP];
  logic [2:0]         half_p[0:NSTEP];
  logic               zero_p[0:NSTEP];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_p[0] <= 1'b0;
    end else begin
      v_p[0] <= in_vld;
    end
    t_p[0]    <= (xn - CENTER) <<< 2;
    acc_p[0]  <= COEF[0];
    odd_p[0]  <= sh_in[0];
    half_p[0] <= sh_in[3:1];
    zero_p[0] <= (in_x[14:0] == 15'd0);
  end

  for (genvar k = 1; k <= NSTEP; k++) begin : g_horner
    always_ff @(posedge clk) begin
      if (!rst_n) v_p[k] <= 1'b0;
      else        v_p[k] <= v_p[k-1];
      acc_p[k]  <= add_sat(mul_hr(t_p[k-1], acc_p[k-1]), COEF[k]);
      t_p[k]    <= t_p[k-1];
      odd_p[k]  <= odd_p[k-1];
      half_p[k] <= half_p[k-1];
      zero_p[k] <= zero_p[k-1];
    end
  end

  logic               v_c, zero_c;
  logic signed [31:0] corr;
  logic [2:0]         half_c;
  logic signed [31:0] poly, scaled, shifted, rounded;
  assign poly   = acc_p[NSTEP];
  assign scaled = add_sat(mul_hr({INV_RT2_HI, 16'h0000}, poly), poly >>> 16);

  always_ff @(posedge clk) begin
    if (!rst_n) v_c <= 1'b0;
    else        v_c <= v_p[NSTEP];
    corr   <= odd_p[NSTEP] ? scaled : poly;
    half_c <= half_p[NSTEP];
    zero_c <= zero_p[NSTEP];
  end

  assign shifted = corr >>> half_c;
  assign rounded = add_sat(shifted, 32'sh00008000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_y   <= 16'h0000;
    end else begin
      out_vld <= v_c;
      out_y   <= zero_c ? 16'h0000 : rounded[31:16];
    end
  end

  logic [2:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n)              warm <= 3'd0;
    else if (warm != 3'd7)   warm <= warm + 3'd1;
  end

  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 3'd7) |-> (out_vld == $past(in_vld, LAT)));

  // R2
  reset_idle_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> !out_vld);

  // R4
  zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm == 3'd7) && $past(in_vld && in_x == 16'h0000, LAT)) |-> (out_y == 16'h0000));

  // R5
  non_negative_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> !out_y[15]);

  // R5
  full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm == 3'd7) && $past(in_vld && in_x == 16'h7FFF, LAT)) |-> (out_y == 16'h7FFF));
endmodule

// File: tb/sqrt_q15_poly_test.sv
module sqrt_q15_poly_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [15:0] in_x = 16'h0000;
  logic        out_vld;
  logic [15:0] out_y;

  int total = 0, bad = 0;
  int cyc = 0;
  int sent_x [0:32767];
  int sent_c [0:32767];
  int wr = 0, rd = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sqrt_q15_poly uut (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_x(in_x),
                     .out_vld(out_vld), .out_y(out_y));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      if (rd >= wr) begin
        check(0, "R1 extra result", rd, wr);
      end else begin
        int x;
        real ref_v, err;
        x = sent_x[rd];
        check(cyc - sent_c[rd] == 7, "R1 latency", cyc - sent_c[rd], 7);
        ref_v = $sqrt(x / 32768.0) * 32768.0;
        err = real'(out_y) - ref_v;
        check(err > -1.0 && err < 1.0, "R3 error bound", int'(out_y), int'(ref_v));
        check(!out_y[15], "R5 sign bit", int'(out_y[15]), 0);
        if (x == 0)      check(out_y == 16'h0000, "R4 zero", int'(out_y), 0);
        if (x == 16'h7FFF) check(out_y == 16'h7FFF, "R5 full scale", int'(out_y), 32767);
        if (x == 16'h2000) check(out_y == 16'h4000, "R7 odd shift", int'(out_y), 16384);
        rd++;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_vld, "R2 reset idle", int'(out_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_vld, "R2 after reset", int'(out_vld), 0);
    for (int x = 0; x < 32768; x++) begin
      if (x % 7 == 3) begin
        in_vld = 1'b0;
        in_x = 16'hFFFF;
        @(negedge clk);
      end
      in_vld = 1'b1;
      in_x = 16'(x);
      sent_x[wr] = x;
      sent_c[wr] = cyc;
      wr++;
      @(negedge clk);
    end
    in_vld = 1'b0;
    in_x = 16'hFFFF;
    repeat (20) @(negedge clk);
    check(rd == 32768, "R6 result count", rd, 32768);
    check(!out_vld, "R1 idle after sweep", int'(out_vld), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", rd, 32768);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule